// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Drive Controller

This block decides, cycle by cycle, which output transistors of one port pin are switched on. The core supplies a two-bit mode code, the value of the pin's output latch, a synchronised copy of the pad level and a one-clock tick that marks each machine cycle. The block returns five signals. Four are enables for the pad drivers: one pull-down and three pull-ups of strong, weak and very weak strength. The fifth is the input level handed back to the core.

The requested mode is registered once per clock into an applied mode. Reset forces the applied mode to quasi-bidirectional. In that mode the very weak pull-up follows the latch. The weak pull-up also needs the sensed level to be high. A 0-to-1 latch edge starts a timed strong pull-up boost.

The boost is a two-state machine. `BST_IDLE` goes to `BST_PULSE` when the latch rises in quasi mode with no mode change pending. `BST_PULSE` returns to `BST_IDLE` for any of three reasons:
- expiry: the `BOOST_TICKS`-th machine-cycle tick arrives;
- cancel: the requested mode differs from the applied one;
- drop: the latch returns to 0.

The sensed level passes through a stability filter in every mode except input-only, where it is handed through directly.

Top module: `qbio_pin_ctrl`

## Requirements
- R1: While reset is held and directly after it, the applied mode is quasi-bidirectional whatever `mode_sel` holds, the boost is idle and the filtered level is 1. With the latch at 1 this gives pull-down 0, strong 0, weak 1, very weak 1 and `in_value` 1.
- R2: `mode_sel` codes are 00 quasi-bidirectional, 01 push-pull, 10 input-only, 11 open-drain. A new code takes effect on the outputs after the next rising clock edge and not before.
- R3: In quasi-bidirectional mode the very weak pull-up enable equals the output latch.
- R4: In quasi-bidirectional mode the weak pull-up is on only while the latch is 1 and the filtered level is 1. It drops once a low pad level has been accepted by the filter.
- R5: In quasi-bidirectional mode, a latch change from 0 to 1 sampled at a clock edge turns the strong pull-up on from that edge. It stays on until the edge that samples the `BOOST_TICKS`-th (default 2) asserted `mc_tick`, and goes off after that edge.
- R6: A running boost ends at once when the latch falls, where the strong enable drops without waiting for a clock. It also ends at the next edge when `mode_sel` differs from the applied mode. Neither event restarts the boost without a new 0-to-1 latch edge.
- R7: In push-pull mode the strong pull-up enable equals the latch; the weak and very weak pull-ups are off.
- R8: In open-drain mode all pull-ups are off. In quasi-bidirectional, push-pull and open-drain modes the pull-down enable is the inverse of the latch.
- R9: In input-only mode all four driver enables are 0, and `in_value` follows `pin_sync` combinationally.
- R10: Outside input-only mode, `in_value` takes a new level only after `pin_sync` has shown it at `STABLE_SAMPLES` (default 3) consecutive rising edges. Shorter excursions are ignored.
- R11: The pull-down is never enabled together with any pull-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Requested pin mode code |
| out_latch | input | 1 | Output latch bit from the core |
| pin_sync | input | 1 | Synchronised pad level |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| pull_dn_en | output | 1 | Pull-down driver enable |
| pu_strong_en | output | 1 | Strong pull-up enable |
| pu_weak_en | output | 1 | Weak pull-up enable |
| pu_vweak_en | output | 1 | Very weak pull-up enable |
| in_value | output | 1 | Input level returned to the core |

## Verification
The bench builds the block with its defaults: a boost length of two machine-cycle ticks and a three-sample filter. With only two ticks, the bench can drive each tick by hand and place the boost's last cycle exactly, so the expiry and both early exits are all checked at single-cycle precision. With three samples, a two-cycle glitch and a three-cycle real change both fit in a few clocks, so the accept/reject boundary is checked from both sides.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

    typedef enum logic [1:0] {
        PM_QUASI = 2'b00,
        PM_PUSH  = 2'b01,
        PM_HIZ   = 2'b10,
        PM_OPEN  = 2'b11
    } pin_mode_e;

    typedef enum logic {
        BST_IDLE  = 1'b0,
        BST_PULSE = 1'b1
    } boost_state_e;

    typedef struct packed {
        logic pull_dn;
        logic pu_strong;
        logic pu_weak;
        logic pu_vweak;
    } drive_t;

endpackage

// File: rtl/qbio_glitch_filter.sv
module qbio_glitch_filter #(
    parameter int   STABLE_SAMPLES = 3,
    parameter logic RESET_LEVEL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = (STABLE_SAMPLES > 1) ? $clog2(STABLE_SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_SAMPLES - 1);

    logic          level_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= RESET_LEVEL;
            run_q   <= '0;
        end else if (raw == level_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            level_q <= raw;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign level = level_q;

endmodule

// File: rtl/qbio_boost_fsm.sv
module qbio_boost_fsm
    import qbio_pkg::*;
#(
    parameter int BOOST_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    input  logic tick,
    output logic active
);
    localparam int CW = (BOOST_TICKS > 1) ? $clog2(BOOST_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BOOST_TICKS - 1);

    boost_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BST_IDLE: begin
                if (start) begin
                    state_d = BST_PULSE;
                    cnt_d   = '0;
                end
            end
            BST_PULSE: begin
                if (cancel) begin
                    state_d = BST_IDLE;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = BST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = BST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            BST_PULSE: active = 1'b1;
            default:   active = 1'b0;
        endcase
    end

endmodule

// File: rtl/qbio_drive_decode.sv
module qbio_drive_decode
    import qbio_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      latch,
    input  logic      sensed,
    input  logic      boost,
    output drive_t    drv
);
    always_comb begin
        drv = '0;
        unique case (mode)
            PM_QUASI: begin
                drv.pull_dn   = !latch;
                drv.pu_strong = latch && boost;
                drv.pu_weak   = latch && sensed;
                drv.pu_vweak  = latch;
            end
            PM_PUSH: begin
                drv.pull_dn   = !latch;
                drv.pu_strong = latch;
            end
            PM_OPEN: begin
                drv.pull_dn   = !latch;
            end
            PM_HIZ: begin
                drv = '0;
            end
            default: drv = '0;
        endcase
    end

endmodule

// File: rtl/qbio_pin_ctrl.sv
module qbio_pin_ctrl
    import qbio_pkg::*;
#(
    parameter int BOOST_TICKS    = 2,
    parameter int STABLE_SAMPLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       out_latch,
    input  logic       pin_sync,
    input  logic       mc_tick,
    output logic       pull_dn_en,
    output logic       pu_strong_en,
    output logic       pu_weak_en,
    output logic       pu_vweak_en,
    output logic       in_value
);
    pin_mode_e mode_req;
    pin_mode_e mode_q;
    logic      latch_q;
    logic      filt_level;
    logic      boost_on;
    logic      boost_start;
    logic      boost_cancel;
    drive_t    drv;

    assign mode_req = pin_mode_e'(mode_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= PM_QUASI;
            latch_q <= 1'b1;
        end else begin
            mode_q  <= mode_req;
            latch_q <= out_latch;
        end
    end

    assign boost_start  = (mode_q == PM_QUASI) && (mode_req == mode_q) &&
                          out_latch && !latch_q;
    assign boost_cancel = (mode_req != mode_q) || !out_latch;

    qbio_glitch_filter #(
        .STABLE_SAMPLES (STABLE_SAMPLES),
        .RESET_LEVEL    (1'b1)
    ) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_sync),
        .level (filt_level)
    );

    qbio_boost_fsm #(
        .BOOST_TICKS (BOOST_TICKS)
    ) boost_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (boost_start),
        .cancel (boost_cancel),
        .tick   (mc_tick),
        .active (boost_on)
    );

    qbio_drive_decode dec_i (
        .mode   (mode_q),
        .latch  (out_latch),
        .sensed (filt_level),
        .boost  (boost_on),
        .drv    (drv)
    );

    assign pull_dn_en   = drv.pull_dn;
    assign pu_strong_en = drv.pu_strong;
    assign pu_weak_en   = drv.pu_weak;
    assign pu_vweak_en  = drv.pu_vweak;
    assign in_value     = (mode_q == PM_HIZ) ? pin_sync : filt_level;

endmodule

// File: rtl/qbio_pin_ctrl_chk.sv
module qbio_pin_ctrl_chk
    import qbio_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input pin_mode_e  mode_q,
    input logic       out_latch,
    input logic       pin_sync,
    input logic       pull_dn_en,
    input logic       pu_strong_en,
    input logic       pu_weak_en,
    input logic       pu_vweak_en,
    input logic       in_value
);
    a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dn_en |-> !(pu_strong_en || pu_weak_en || pu_vweak_en));

    a_r9_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_HIZ) |->
            (!pull_dn_en && !pu_strong_en && !pu_weak_en && !pu_vweak_en &&
             in_value == pin_sync));

    a_r8_open_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_OPEN) |-> !(pu_strong_en || pu_weak_en || pu_vweak_en));

    a_r5_boost_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pu_strong_en) && mode_q == PM_QUASI) |->
            ($past(mode_sel) == 2'b00 && $past(out_latch) && !$past(out_latch, 2)));

    a_r6_mode_change_ends_boost: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != mode_q && mode_sel != 2'b01) |=> !pu_strong_en);

    a_r10_filter_accepts_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PM_HIZ && $past(mode_q) != PM_HIZ && !$stable(in_value)) |->
            (in_value == $past(pin_sync)));

endmodule

bind qbio_pin_ctrl qbio_pin_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .mode_q       (mode_q),
    .out_latch    (out_latch),
    .pin_sync     (pin_sync),
    .pull_dn_en   (pull_dn_en),
    .pu_strong_en (pu_strong_en),
    .pu_weak_en   (pu_weak_en),
    .pu_vweak_en  (pu_vweak_en),
    .in_value     (in_value)
);

// File: tb/qbio_pin_ctrl_tb_top.sv
module qbio_pin_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       out_latch;
    logic       pin_sync;
    logic       mc_tick;
    logic       pull_dn_en, pu_strong_en, pu_weak_en, pu_vweak_en, in_value;

    int checks = 0;
    int errors = 0;
    bit auto_tick = 1'b0;
    int tph = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    qbio_pin_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .out_latch    (out_latch),
        .pin_sync     (pin_sync),
        .mc_tick      (mc_tick),
        .pull_dn_en   (pull_dn_en),
        .pu_strong_en (pu_strong_en),
        .pu_weak_en   (pu_weak_en),
        .pu_vweak_en  (pu_vweak_en),
        .in_value     (in_value)
    );

    // {mode[1:0], latch, pin, pull_dn, strong, weak, vweak, in_value}
    localparam logic [8:0] VEC [0:10] = '{
        9'b001100111, 9'b001000010, 9'b000010000, 9'b000110001,
        9'b011101001, 9'b010010000, 9'b101000000, 9'b100100001,
        9'b111100001, 9'b110010000, 9'b111000000
    };

    function automatic logic [4:0] obs();
        return {pull_dn_en, pu_strong_en, pu_weak_en, pu_vweak_en, in_value};
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            if (auto_tick) mc_tick = (tph == 3);
            @(posedge clk);
            #2;
            tph = (tph + 1) % 4;
        end
    endtask

    task automatic set_auto(input bit on);
        auto_tick = on;
        mc_tick   = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_sel = 2'b01; out_latch = 1'b1; pin_sync = 1'b1; mc_tick = 1'b0;
        run(2);
        // R1: push-pull requested during reset still behaves as quasi
        chk("R1 reset held", obs(), 5'b00111);
        mode_sel = 2'b00;
        rst_n = 1'b1;
        run(1);
        chk("R1 after reset", obs(), 5'b00111);

        // Table walk: R2 R3 R4 R7 R8 R9 steady state per mode
        set_auto(1'b1);
        for (int v = 0; v < 11; v++) begin
            string tag;
            mode_sel  = VEC[v][8:7];
            out_latch = VEC[v][6];
            pin_sync  = VEC[v][5];
            run(12);
            case (VEC[v][8:7])
                2'b00:   tag = "R2 R3 R4 quasi vec";
                2'b01:   tag = "R2 R7 push vec";
                2'b10:   tag = "R2 R9 hiz vec";
                default: tag = "R2 R8 open vec";
            endcase
            chk($sformatf("%s %0d", tag, v), obs(), VEC[v][4:0]);
        end

        // R10 / R4: glitch rejection and acceptance in quasi mode
        set_auto(1'b0);
        mode_sel = 2'b00; out_latch = 1'b1; pin_sync = 1'b1;
        run(6);
        pin_sync = 1'b0; run(2);
        chk("R10 two-sample low ignored", obs(), 5'b00111);
        pin_sync = 1'b1; run(3);
        chk("R10 level kept", obs(), 5'b00111);
        pin_sync = 1'b0; run(2);
        chk("R10 not yet accepted", obs(), 5'b00111);
        run(1);
        chk("R4 R10 low accepted weak off", obs(), 5'b00010);
        chk("R3 vweak follows latch", {4'b0, pu_vweak_en}, 5'b00001);

        // R9: input-only bypass
        mode_sel = 2'b10; run(1);
        chk("R9 hiz in low", obs(), 5'b00000);
        pin_sync = 1'b1; #1;
        chk("R9 hiz bypass high", obs(), 5'b00001);
        pin_sync = 1'b0; #1;
        chk("R9 hiz bypass low", obs(), 5'b00000);
        pin_sync = 1'b1;
        run(5);

        // R2: mode takes effect after the next edge
        mode_sel = 2'b00; run(4);
        mode_sel = 2'b01; #1;
        chk("R2 before edge", {3'b0, pu_strong_en, pu_vweak_en}, 5'b00001);
        run(1);
        chk("R2 after edge", {3'b0, pu_strong_en, pu_vweak_en}, 5'b00010);

        // R5: boost length with manual ticks
        mode_sel = 2'b00; out_latch = 1'b0; run(3);
        out_latch = 1'b1; run(1);
        chk("R5 boost on", obs(), 5'b01111);
        run(3);
        chk("R5 boost held without ticks", obs(), 5'b01111);
        mc_tick = 1'b1; run(1); mc_tick = 1'b0;
        chk("R5 boost after first tick", obs(), 5'b01111);
        run(2);
        mc_tick = 1'b1; run(1); mc_tick = 1'b0;
        chk("R5 boost ends at second tick", obs(), 5'b00111);

        // R6: cancel by mode change
        out_latch = 1'b0; run(2);
        out_latch = 1'b1; run(1);
        chk("R6 boost started", obs(), 5'b01111);
        mode_sel = 2'b11; run(1);
        chk("R6 open cancels boost", obs(), 5'b00001);
        mode_sel = 2'b00; run(1);
        chk("R6 no restart on return", obs(), 5'b00111);
        set_auto(1'b1); run(10); set_auto(1'b0);
        chk("R6 still no boost", obs(), 5'b00111);

        // R6 / R11: cancel by latch fall
        out_latch = 1'b0; run(1);
        out_latch = 1'b1; run(1);
        chk("R6 boost before drop", obs(), 5'b01111);
        out_latch = 1'b0; #1;
        chk("R6 R11 latch drop immediate", obs(), 5'b10001);
        run(1);
        out_latch = 1'b1; run(1);
        chk("R5 new rise restarts boost", obs(), 5'b01111);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule